// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial protocol engine of a byte-addressed nonvolatile memory model. While a write sequence runs, each data byte that is received arrives with a strobe, a 5-bit column inside the current page and the page row. The byte goes into a 32-entry page buffer and sets that column's valid flag. A byte that lands on a column already written in the same sequence replaces the earlier one. Because the column is only 5 bits wide, a sequence longer than one page wraps around to the start of the same page.

When the protocol engine reports a stop and the buffer holds at least one byte, the block begins a commit. It raises `busy` for a fixed number of clock cycles, which stands in for the self-timed programming interval. In the first cycles of that interval it puts each valid byte on the memory write port, one per clock, in ascending column order. When `busy` drops, the buffer is empty again. While `busy` is high, the protocol engine is gated: strobes and stops that reach the block are dropped. The write-protect input is sampled at the stop. If it is high and the page lies in the top quarter of the address space, the buffer is discarded and no interval starts.

Top module: `page_commit_ctrl`

## Requirements
- R1: A byte strobe stores the data at its column (`mem_addr` = {row, column}, column in bits 4:0). A later strobe to the same column in the same sequence replaces the earlier data, so a sequence of more than 32 bytes keeps only the last byte for each column.
- R2: A commit writes exactly the columns that received a byte, one per clock, in ascending column order. The first write is presented in the cycle after the stop. Columns that received no byte are never written.
- R3: A stop taken while idle with at least one buffered byte, and not blocked by write protect, raises `busy` in the following cycle.
- R4: `busy` stays high for exactly PROG_CYCLES clock cycles. Byte strobes and stops that arrive while it is high have no effect.
- R5: A stop taken while the buffer is empty starts no interval and produces no write.
- R6: If `wp` is 1 in the stop cycle and the page row lies in the top quarter (row[7:6] = 2'b11, bytes 0x1800 to 0x1FFF), no byte is written, `busy` stays low, and the buffer is emptied.
- R7: With `wp` at 0, pages in the top quarter commit normally. With `wp` at 1, pages below the top quarter commit normally.
- R8: The buffer is empty once `busy` falls, so a stop directly after a finished commit writes nothing.
- R9: After reset, `busy` and `mem_we` are 0 and the buffer is empty.
- R10: A byte strobe in the same cycle as a stop is discarded. The stop commits only the bytes taken before it.
- R11: `mem_we` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One-cycle strobe: a data byte has been received |
| byte_col | input | 5 | Column of the byte within its page |
| byte_data | input | 8 | Received data byte |
| page_row | input | 8 | Page row of the current write sequence |
| stop_pulse | input | 1 | One-cycle stop indication from the protocol engine |
| wp | input | 1 | Write-protect level for the top quarter |
| busy | output | 1 | Programming interval in progress; gates the protocol engine |
| mem_we | output | 1 | Memory array write enable |
| mem_addr | output | 13 | Memory array byte address |
| mem_wdata | output | 8 | Memory array write data |

## Verification
The bench aims at several corner cases. Sequences longer than a page must wrap and overwrite: a design that let later bytes spill into the next row, or kept the first byte of a column, writes the wrong address or data. Partial pages and scattered columns catch a design that writes the whole page or writes out of column order. Protected-page stops under both levels of `wp` catch a design that ignores the protect pin, applies it to the wrong quarter, or leaves the blocked bytes to commit on the next stop. Strobes and stops sent during `busy`, or in the stop cycle itself, expose a design that does not gate its inputs, because the following stop then finds a non-empty buffer.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;

  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_PROG = 1'b1
  } cm_state_t;

  // A row belongs to the protected region when it is in the top quarter.
  function automatic bit in_top_quarter(input int unsigned row, input int unsigned rows);
    return row >= (rows - rows / 4);
  endfunction

  // Flat byte address of a (row, column) pair.
  function automatic int unsigned flat_addr(input int unsigned row, input int unsigned col,
                                            input int unsigned page_bytes);
    return row * page_bytes + col;
  endfunction

endpackage

// File: rtl/page_store.sv
module page_store #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);

  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slot_vld;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    wire hit = wr_en && (wr_col == COL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g]  <= 1'b0;
        slot_data[g] <= '0;
      end else if (clr) begin
        slot_vld[g]  <= 1'b0;
      end else if (hit) begin
        slot_vld[g]  <= 1'b1;
        slot_data[g] <= wr_data;
      end
    end
  end

  assign rd_data   = slot_data[rd_col];
  assign rd_valid  = slot_vld[rd_col];
  assign any_valid = |slot_vld;

endmodule

// File: rtl/commit_engine.sv
module commit_engine
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 64,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             scan_active,
  output logic [COL_W-1:0] scan_col,
  output logic             done
);

  cm_state_t        state;
  logic [CNT_W-1:0] cnt;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN = CNT_W'(PAGE_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CM_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        CM_IDLE: if (start) begin
          state <= CM_PROG;
          cnt   <= '0;
        end
        CM_PROG: if (cnt == LAST) begin
          state <= CM_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= CM_IDLE;
      endcase
    end
  end

  assign busy        = (state == CM_PROG);
  assign scan_active = busy && (cnt < SCAN);
  assign scan_col    = cnt[COL_W-1:0];
  assign done        = busy && (cnt == LAST);

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES  = 32,
  parameter int MEM_BYTES   = 8192,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 64,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int ROW_W      = ADDR_W - COL_W,
  localparam int ROWS       = MEM_BYTES / PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [COL_W-1:0]  byte_col,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [ROW_W-1:0]  page_row,
  input  logic              stop_pulse,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [ROW_W-1:0]  row_q;
  logic              any_valid;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [COL_W-1:0]  scan_col;
  logic              scan_active;

  // Named events for the checker.
  logic accept_byte;
  logic stop_seen;
  logic row_locked;
  logic commit_start;
  logic commit_blocked;
  logic commit_done;

  assign accept_byte    = byte_stb && !busy && !stop_pulse;
  assign stop_seen      = stop_pulse && !busy;
  assign row_locked     = wp && in_top_quarter(int'(row_q), ROWS);
  assign commit_start   = stop_seen && any_valid && !row_locked;
  assign commit_blocked = stop_seen && any_valid && row_locked;

  always_ff @(posedge clk) begin
    if (!rst_n)           row_q <= '0;
    else if (accept_byte) row_q <= page_row;
  end

  page_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept_byte),
    .wr_col    (byte_col),
    .wr_data   (byte_data),
    .clr       (commit_blocked || commit_done),
    .rd_col    (scan_col),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  commit_engine #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (commit_start),
    .busy        (busy),
    .scan_active (scan_active),
    .scan_col    (scan_col),
    .done        (commit_done)
  );

  assign mem_we    = scan_active && rd_valid;
  assign mem_addr  = ADDR_W'(flat_addr(int'(row_q), int'(scan_col), PAGE_BYTES));
  assign mem_wdata = rd_data;

endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mem_we,
  input logic stop_seen,
  input logic any_valid,
  input logic commit_start,
  input logic commit_blocked,
  input logic accept_byte
);

  logic [31:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1;
    else           run <= '0;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> busy);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 32'(PROG_CYCLES)));

  p_no_input_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_byte);

  p_empty_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !any_valid) |=> !busy);

  p_blocked_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_blocked |=> (!busy && !any_valid));

  p_empty_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_valid);

  p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

endmodule

bind page_commit_ctrl page_commit_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .mem_we         (mem_we),
  .stop_seen      (stop_seen),
  .any_valid      (any_valid),
  .commit_start   (commit_start),
  .commit_blocked (commit_blocked),
  .accept_byte    (accept_byte)
);

// File: tb/sim_page_commit_ctrl.sv
module sim_page_commit_ctrl;

  localparam int CLK_P = 10;
  localparam int PROG  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_stb = 1'b0;
  logic [4:0]  byte_col = '0;
  logic [7:0]  byte_data = '0;
  logic [7:0]  page_row = '0;
  logic        stop_pulse = 1'b0;
  logic        wp = 1'b0;
  logic        busy;
  logic        mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  logic [20:0] wlog[$];
  logic [7:0]  m_data [32];
  bit          m_vld  [32];
  logic [7:0]  m_row;

  always #(CLK_P/2) clk = ~clk;

  page_commit_ctrl #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_col(byte_col),
    .byte_data(byte_data), .page_row(page_row), .stop_pulse(stop_pulse),
    .wp(wp), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) if (mem_we) wlog.push_back({mem_addr, mem_wdata});

  function automatic bit prot_row(input logic [7:0] r);
    return (r >> 6) == 8'd3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
  endtask

  task automatic send_byte(input logic [4:0] c, input logic [7:0] d, input logic [7:0] r);
    byte_stb = 1; byte_col = c; byte_data = d; page_row = r;
    @(negedge clk);
    byte_stb = 0;
    m_vld[c] = 1; m_data[c] = d; m_row = r;
  endtask

  // Stop, then check the start of busy, its length and the write log.
  task automatic stop_and_check(input bit wpv, input bit junk, input bit extra_byte);
    bit any = 0;
    bit commit;
    int n = 0;
    int e = 0;
    for (int i = 0; i < 32; i++) any |= m_vld[i];
    commit = any && !(wpv && prot_row(m_row));
    wlog.delete();
    stop_pulse = 1; wp = wpv;
    if (extra_byte) begin byte_stb = 1; byte_col = 5'd5; byte_data = 8'hEE; end
    @(negedge clk);
    stop_pulse = 0; byte_stb = 0;
    chk(commit ? "R3 busy start" : (any ? "R6 blocked busy" : "R5 empty stop"), busy, commit);
    while (busy && n < PROG + 10) begin
      n++;
      if (junk && n == 5) begin
        byte_stb = 1; byte_col = 5'd9; byte_data = 8'h5A; stop_pulse = 1;
      end else begin
        byte_stb = 0; stop_pulse = 0;
      end
      @(negedge clk);
    end
    byte_stb = 0; stop_pulse = 0;
    if (commit) chk("R4 busy length", n, PROG);
    for (int c = 0; c < 32; c++) if (commit && m_vld[c]) begin
      if (e < wlog.size())
        chk(wpv ? "R7 write wp" : "R2 write", wlog[e], {m_row, c[4:0], m_data[c]});
      e++;
    end
    chk(wpv && prot_row(m_row) ? "R6 write count" : "R1 write count", wlog.size(), e);
    model_clear();
    // Buffer must be empty now (R8, R4 junk, R6 cleared, R10 discard).
    wlog.delete();
    stop_pulse = 1; wp = 0;
    @(negedge clk);
    stop_pulse = 0;
    chk("R8 empty after commit", busy, 0);
    @(negedge clk);
    chk("R8 no write after commit", wlog.size(), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset we", mem_we, 0);

    // R5: stop with empty buffer.
    stop_and_check(0, 0, 0);
    // R1: single byte; R2 partial.
    send_byte(5'd7, 8'hA1, 8'd3);
    stop_and_check(0, 0, 0);
    // R1 wrap: 40 bytes from column 28.
    for (int i = 0; i < 40; i++) send_byte(5'((28 + i) % 32), 8'(i + 8'h10), 8'd20);
    stop_and_check(0, 0, 0);
    // R6: protected page blocked.
    send_byte(5'd0, 8'h33, 8'd200); send_byte(5'd31, 8'h44, 8'd200);
    stop_and_check(1, 0, 0);
    // R7: top quarter with wp low; lower page with wp high.
    send_byte(5'd2, 8'h55, 8'd255);
    stop_and_check(0, 0, 0);
    send_byte(5'd4, 8'h66, 8'd191);
    stop_and_check(1, 0, 0);
    // R4: inputs during busy ignored.
    send_byte(5'd1, 8'h77, 8'd9);
    stop_and_check(0, 1, 0);
    // R10: byte in stop cycle discarded.
    send_byte(5'd3, 8'h88, 8'd11);
    stop_and_check(0, 0, 1);

    // Random sequences.
    for (int t = 0; t < 40; t++) begin
      logic [7:0] r = 8'($urandom);
      int cnt = $urandom_range(0, 45);
      int st  = $urandom_range(0, 31);
      bit scat = ($urandom_range(0, 2) == 0);
      for (int i = 0; i < cnt; i++)
        send_byte(scat ? 5'($urandom) : 5'((st + i) % 32), 8'($urandom), r);
      stop_and_check(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0), 1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule